// File: doc/BRIEF.md
# Serial-Load DAC Input Register Chain

This block is the digital front end of a 14-bit voltage-output converter. It runs entirely in the system clock domain and oversamples three pins: a serial clock, a serial data line and an active-low select/load line. While select is low, each genuine rising edge of the serial clock shifts one data bit into a 16-bit frame register, most significant bit first. When select returns high, the upper 14 bits of the frame register are copied into a holding register that drives the parallel converter code.

The top bit of the frame register is brought out as a serial chain output. Several of these blocks can share the serial clock and select/load line with each one's data input fed from the previous one's chain output; a long bit stream then distributes one 16-bit word per block, and a single rising edge of select updates every code at the same moment. The analog converter, its buffer and reference lie outside this block. The system clock must run at least four times the serial clock rate.

Top module: `sdac_front`

## Requirements
- R1: On each rising serial clock edge accepted while select is low, the frame register shifts left by one and the sampled data bit enters bit 0, so the first bit sent ends up in bit 15 of a 16-bit frame.
- R2: The code loaded is frame register bits [15:2]; the last two bits of a 16-bit frame never reach the code.
- R3: Serial clock edges seen while select is high leave the frame register and the code untouched.
- R4: The code changes only on a low-to-high transition of select, which copies frame bits [15:2] into it; during a frame the code keeps its old value.
- R5: The chain output always equals bit 15 of the frame register, so after 16 accepted clocks it has emitted the previous frame word, first bit first.
- R6: An active-low power-on reset clears the frame register, the code and the chain output to zero.
- R7: A serial clock already high when select falls causes no shift; only a later low-to-high clock transition counts.
- R8: Frames shorter or longer than 16 clocks are not rejected; whatever the frame register holds when select rises is loaded.
- R9: Two blocks chained through the chain output and sharing serial clock and select receive consecutive 16-bit words of one stream, the later word in the block nearest the stream source, and both codes update on the same select rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porN | input | 1 | Active-low power-on reset, asynchronous |
| sclkPin | input | 1 | Serial clock pin, asynchronous |
| dinPin | input | 1 | Serial data pin, asynchronous |
| selNPin | input | 1 | Active-low select; rising edge loads the code |
| serOut | output | 1 | Chain output, frame register bit 15 |
| dacCode | output | 14 | Holding register code to the converter |

## Verification
A serial clock rise and a select rise can land in the same system cycle when both pins move together, since they pass through identical synchronizers. The bench provokes this by raising both pins at one instant after fifteen bits of a frame and judges it by the loaded code: it must reflect the frame register before that clock, showing the shift was blocked and the load took the pre-edge contents. The same-instant case of a clock already high as select falls is provoked and judged the same way, by an exact 16-bit frame loading with no extra shift.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Strobes from the control half to the datapath half, one system cycle wide.
  typedef struct packed {
    logic shift;  // accept one serial bit into the frame register
    logic load;   // copy the code field into the holding register
  } sdacStrobe_t;

  // Bit positions inside the synchronized pin bundle.
  localparam int PIN_SCLK = 0;
  localparam int PIN_DIN  = 1;
  localparam int PIN_SELN = 2;
  localparam int PIN_CNT  = 3;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              WIDTH     = 3,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RESET_VAL;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        sclkSync,
  input  logic        selNSync,
  output sdacStrobe_t strb
);

  logic sclkPrev;
  logic selNPrev;

  // Previous samples; select idles high so its history resets high.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sclkPrev <= 1'b0;
      selNPrev <= 1'b1;
    end else begin
      sclkPrev <= sclkSync;
      selNPrev <= selNSync;
    end
  end

  logic sclkRise;
  logic selRise;

  always_comb begin
    sclkRise   = sclkSync & ~sclkPrev;
    selRise    = selNSync & ~selNPrev;
    // A clock level that is already high when select drops is no edge,
    // so it never produces a shift.
    strb.shift = sclkRise & ~selNSync;
    strb.load  = selRise;
  end

endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 14
) (
  input  logic              clk,
  input  logic              porN,
  input  sdacStrobe_t       strb,
  input  logic              dinSync,
  output logic [FRAME_W-1:0] frameReg,
  output logic [CODE_W-1:0]  codeReg,
  output logic              serOut
);

  localparam int TOP = FRAME_W - 1;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      frameReg <= '0;
    end else if (strb.shift) begin
      frameReg <= {frameReg[TOP-1:0], dinSync};
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      codeReg <= '0;
    end else if (strb.load) begin
      codeReg <= frameReg[TOP -: CODE_W];
    end
  end

  assign serOut = frameReg[TOP];

endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int CODE_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sclkPin,
  input  logic              dinPin,
  input  logic              selNPin,
  output logic              serOut,
  output logic [CODE_W-1:0] dacCode
);

  localparam logic [PIN_CNT-1:0] SYNC_RST = PIN_CNT'(1) << PIN_SELN;

  logic [PIN_CNT-1:0] pinRaw;
  logic [PIN_CNT-1:0] pinSync;
  logic               sclkSync;
  logic               dinSync;
  logic               selNSync;
  sdacStrobe_t        strb;
  logic [FRAME_W-1:0] frameReg;

  always_comb begin
    pinRaw           = '0;
    pinRaw[PIN_SCLK] = sclkPin;
    pinRaw[PIN_DIN]  = dinPin;
    pinRaw[PIN_SELN] = selNPin;
  end

  sdac_sync #(
    .WIDTH    (PIN_CNT),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .porN   (porN),
    .asyncIn(pinRaw),
    .syncOut(pinSync)
  );

  assign sclkSync = pinSync[PIN_SCLK];
  assign dinSync  = pinSync[PIN_DIN];
  assign selNSync = pinSync[PIN_SELN];

  sdac_ctrl u_ctrl (
    .clk     (clk),
    .porN    (porN),
    .sclkSync(sclkSync),
    .selNSync(selNSync),
    .strb    (strb)
  );

  sdac_datapath #(
    .FRAME_W(FRAME_W),
    .CODE_W (CODE_W)
  ) u_dp (
    .clk     (clk),
    .porN    (porN),
    .strb    (strb),
    .dinSync (dinSync),
    .frameReg(frameReg),
    .codeReg (dacCode),
    .serOut  (serOut)
  );

endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 14
) (
  input logic              clk,
  input logic              porN,
  input sdacStrobe_t       strb,
  input logic              dinSync,
  input logic              selNSync,
  input logic [FRAME_W-1:0] frameReg,
  input logic              serOut,
  input logic [CODE_W-1:0]  dacCode
);

  // R1: an accepted edge shifts left and inserts the sampled bit
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!porN)
    strb.shift |=> frameReg == {$past(frameReg[FRAME_W-2:0]), $past(dinSync)});

  // R3: while select is high the frame register holds
  a_r3_blocked_when_high: assert property (@(posedge clk) disable iff (!porN)
    selNSync |=> $stable(frameReg));

  // R4 / R2: a select rise copies the top code field
  a_r4_load_copies: assert property (@(posedge clk) disable iff (!porN)
    strb.load |=> dacCode == $past(frameReg[FRAME_W-1 -: CODE_W]));

  // R4: without a load the code is held
  a_r4_code_held: assert property (@(posedge clk) disable iff (!porN)
    !strb.load |=> $stable(dacCode));

  // R5: chain output follows the top frame stage
  a_r5_chain_top: assert property (@(posedge clk) disable iff (!porN)
    serOut == frameReg[FRAME_W-1]);

endmodule

bind sdac_front sdac_front_chk #(
  .FRAME_W(FRAME_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk     (clk),
  .porN    (porN),
  .strb    (strb),
  .dinSync (dinSync),
  .selNSync(selNSync),
  .frameReg(frameReg),
  .serOut  (serOut),
  .dacCode (dacCode)
);

// File: tb/tb_sdac_front.sv
`timescale 1ns/1ps
module tb_sdac_front;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic sclkPin = 1'b0;
  logic dinPin = 1'b0;
  logic selNPin = 1'b1;
  logic serOut, serOut2;
  logic [13:0] dacCode, dacCode2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected frame registers and codes, near block (1) and far block (2)
  logic [15:0] m1 = '0, m2 = '0;
  logic [13:0] c1 = '0, c2 = '0;

  always #2.5 clk = ~clk;

  sdac_front dut (
    .clk(clk), .porN(porN), .sclkPin(sclkPin), .dinPin(dinPin),
    .selNPin(selNPin), .serOut(serOut), .dacCode(dacCode)
  );

  sdac_front dut2 (
    .clk(clk), .porN(porN), .sclkPin(sclkPin), .dinPin(serOut),
    .selNPin(selNPin), .serOut(serOut2), .dacCode(dacCode2)
  );

  task automatic waitSys(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkCodes(string req);
    check(dacCode == c1, req, 32'(dacCode), 32'(c1));
    check(dacCode2 == c2, req, 32'(dacCode2), 32'(c2));
    check(serOut == m1[15], req, 32'(serOut), 32'(m1[15]));
  endtask

  task automatic clkBit(bit b);
    dinPin = b;
    waitSys(4);
    sclkPin = 1'b1;
    m2 = {m2[14:0], m1[15]};
    m1 = {m1[14:0], b};
    waitSys(4);
    sclkPin = 1'b0;
  endtask

  task automatic sendBits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) clkBit(w[i]);
  endtask

  task automatic frameOpen();
    selNPin = 1'b0;
    waitSys(4);
  endtask

  task automatic frameClose();
    waitSys(4);
    selNPin = 1'b1;
    c1 = m1[15:2];
    c2 = m2[15:2];
    waitSys(8);
  endtask

  task automatic t_reset();
    porN = 1'b0;
    waitSys(3);
    m1 = '0; m2 = '0; c1 = '0; c2 = '0;
    checkCodes("R6 reset");
    porN = 1'b1;
    waitSys(4);
    checkCodes("R6 after release");
  endtask

  task automatic t_basic();
    logic [13:0] oldCode;
    oldCode = c1;
    frameOpen();
    sendBits(32'hABCD, 16);
    waitSys(4);
    check(dacCode == oldCode, "R4 held before select rise", 32'(dacCode), 32'(oldCode));
    check(serOut == 1'b1, "R5 chain top bit", 32'(serOut), 32'h1);
    frameClose();
    check(dacCode == 14'h2AF3, "R1 msb first code", 32'(dacCode), 32'h2AF3);
    checkCodes("R1 basic frame");
  endtask

  task automatic t_dropTail();
    frameOpen(); sendBits(32'h5A5B, 16); frameClose();
    check(dacCode == 14'h1696, "R2 tail bits 11", 32'(dacCode), 32'h1696);
    frameOpen(); sendBits(32'h5A58, 16); frameClose();
    check(dacCode == 14'h1696, "R2 tail bits 00", 32'(dacCode), 32'h1696);
  endtask

  task automatic t_blocked();
    dinPin = 1'b1;
    for (int i = 0; i < 5; i++) begin
      waitSys(4); sclkPin = 1'b1; waitSys(4); sclkPin = 1'b0;
    end
    waitSys(4);
    checkCodes("R3 clocks with select high");
    frameOpen(); frameClose();
    checkCodes("R3 frame register untouched");
  endtask

  task automatic t_spurious();
    sclkPin = 1'b1;
    dinPin = 1'b1;
    waitSys(4);
    selNPin = 1'b0;
    waitSys(4);
    sclkPin = 1'b0;
    waitSys(4);
    sendBits(32'h3C96, 16);
    frameClose();
    check(dacCode == 14'(16'h3C96 >> 2), "R7 no spurious shift", 32'(dacCode), 32'(16'h3C96 >> 2));
    checkCodes("R7 chain state");
  endtask

  task automatic t_oddLength();
    frameOpen(); sendBits(32'h2A5, 10); frameClose();
    checkCodes("R8 short frame");
    frameOpen(); sendBits(32'h2B3C7, 18); frameClose();
    check(dacCode == 14'(16'hB3C7 >> 2), "R8 long frame", 32'(dacCode), 32'(16'hB3C7 >> 2));
    checkCodes("R8 long frame chain");
  endtask

  task automatic t_chain();
    frameOpen();
    sendBits(32'h1357_9BDF, 32);
    frameClose();
    check(dacCode == 14'(16'h9BDF >> 2), "R9 near word", 32'(dacCode), 32'(16'h9BDF >> 2));
    check(dacCode2 == 14'(16'h1357 >> 2), "R9 far word", 32'(dacCode2), 32'(16'h1357 >> 2));
    checkCodes("R5 R9 chain");
  endtask

  task automatic t_sameCycle();
    frameOpen();
    sendBits(32'h0F0F, 15);
    dinPin = 1'b1;
    waitSys(4);
    sclkPin = 1'b1;
    selNPin = 1'b1;
    c1 = m1[15:2];
    c2 = m2[15:2];
    waitSys(8);
    sclkPin = 1'b0;
    waitSys(4);
    checkCodes("R3 R4 clock and select rise together");
  endtask

  task automatic t_resetMid();
    frameOpen();
    sendBits(32'hFF, 8);
    porN = 1'b0;
    waitSys(2);
    m1 = '0; m2 = '0; c1 = '0; c2 = '0;
    checkCodes("R6 reset mid frame");
    selNPin = 1'b1;
    porN = 1'b1;
    waitSys(8);
    checkCodes("R6 after mid reset");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    waitSys(2);
    t_reset();
    t_basic();
    t_dropTail();
    t_blocked();
    t_spurious();
    t_oddLength();
    t_chain();
    t_sameCycle();
    t_resetMid();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

endmodule